// File: doc/BRIEF.md
# Centred Active-Video Window Generator

This block times the output raster of a standard-definition digital TV encoder. Two free-running counters run in encoder clocks: one across the line and one down the field. Both read zero at the leading edge of their sync pulse. A 50/60 Hz select and the requested active width (in pixels) and height (in lines) go in. From these the block works out a picture window that sits centred in the visible area of the chosen standard. Each output pixel takes two encoder clocks. The block drives the two counts, horizontal and vertical sync pulses, and a flag that is high inside the window.

The sizes and the standard are plain input ports. They are captured only when the raster wraps to the start of a new field, and also while reset is held, so a window never changes shape partway through a field. Requests larger than the standard allows are clamped. The encoder clock is nominally 27 MHz. The geometry of each standard is a parameter with the broadcast numbers as defaults, so a bench can shrink the raster.

Top module: `video_window_gen`

## Requirements
- R1: The horizontal count starts at 0 and steps by one every clock. After the last position of the line it returns to 0. A line lasts 1716 clocks in 60 Hz mode and 1728 clocks in 50 Hz mode.
- R2: The line count steps by one on each horizontal wrap and returns to 0 after the last line of the field. A field has 262 lines (60 Hz) or 312 lines (50 Hz).
- R3: `hsync` is high while the horizontal count is below `HSYNC_CLKS` (default 126). `vsync` is high while the line count is below `VSYNC_LINES` (default 3).
- R4: `sel_50hz` = 0 selects 60 Hz and 1 selects 50 Hz. The window begins at horizontal count origin + maximum − P, where P is the clamped pixel request. The origin and maximum are 256 and 710 at 60 Hz, and 284 and 702 at 50 Hz.
- R5: The window ends (exclusive) at its start plus 2·P, since each pixel lasts two clocks.
- R6: The first active line is the first video line plus floor((maximum lines − L) / 2), where L is the clamped line request. The first video line and maximum are 19 and 240 at 60 Hz, and 23 and 287 at 50 Hz.
- R7: The last active line bound (exclusive) is the first active line plus L.
- R8: Pixel or line requests above the mode's maximum act as that maximum.
- R9: The standard and the size inputs take effect only from the first clock of a new field, or from reset. Changes during a field do not alter that field.
- R10: A synchronous active-high reset holds both counts at 0 and `active` low.
- R11: A pixel or line request of zero produces a field with `active` never high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_50hz | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| out_pix | input | 10 | Requested active pixels per line |
| out_lin | input | 9 | Requested active lines per field |
| h_cnt | output | 11 | Position in the line, in encoder clocks |
| v_cnt | output | 9 | Line index within the field |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| active | output | 1 | High inside the centred window |

## Verification
The assertions assume that the geometry parameters are self-consistent. The sync pulses must end before the visible origin, and the largest window must end before the line and field wrap. Only under those conditions are the sync-blanking and window-bound properties meaningful. The bench picks a scaled raster that keeps these relations, so that many fields fit in a short run. It changes the inputs on falling edges, roughly halfway through a field, so every capture point sees a settled value. This also exercises the rule that mid-field requests must wait for the next field.

// File: rtl/vw_pkg.sv
package vw_pkg;

    localparam int H_W   = 11;
    localparam int V_W   = 9;
    localparam int PIX_W = 10;
    localparam int LIN_W = 9;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } std_e;

    typedef struct packed {
        std_e           std;
        logic [H_W-1:0] h_start;
        logic [H_W-1:0] h_stop;
        logic [V_W-1:0] v_first;
        logic [V_W-1:0] v_stop;
    } win_t;

    function automatic int clamp_to(input int req, input int lim);
        return (req > lim) ? lim : req;
    endfunction

    // Centres the requested window inside the visible area of a standard.
    function automatic win_t calc_window(
        input std_e             s,
        input logic [PIX_W-1:0] pix,
        input logic [LIN_W-1:0] lin,
        input int hf60, input int hm60, input int vf60, input int vm60,
        input int hf50, input int hm50, input int vf50, input int vm50
    );
        win_t w;
        int   hf, hm, vf, vm, p, l, hs, vs;
        hf = (s == STD_50) ? hf50 : hf60;
        hm = (s == STD_50) ? hm50 : hm60;
        vf = (s == STD_50) ? vf50 : vf60;
        vm = (s == STD_50) ? vm50 : vm60;
        p  = clamp_to(int'(pix), hm);
        l  = clamp_to(int'(lin), vm);
        hs = hf + hm - p;
        vs = vf + (vm - l) / 2;
        w.std     = s;
        w.h_start = H_W'(hs);
        w.h_stop  = H_W'(hs + 2 * p);
        w.v_first = V_W'(vs);
        w.v_stop  = V_W'(vs + l);
        return w;
    endfunction

endpackage

// File: rtl/vw_counter.sv
module vw_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    assign wrap = (cnt_q == last);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en)
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> (cnt_q == $past(cnt_q) + W'(1))); // R1, R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && wrap) |=> (cnt_q == '0)); // R1, R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/vw_cfg.sv
module vw_cfg
    import vw_pkg::*;
#(
    parameter int HF60 = 256, parameter int HM60 = 710,
    parameter int VF60 = 19,  parameter int VM60 = 240,
    parameter int HF50 = 284, parameter int HM50 = 702,
    parameter int VF50 = 23,  parameter int VM50 = 287
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             sel_50hz,
    input  logic [PIX_W-1:0] out_pix,
    input  logic [LIN_W-1:0] out_lin,
    output win_t             cfg
);

    localparam int H_LIM60 = HF60 + 2 * HM60;
    localparam int H_LIM50 = HF50 + 2 * HM50;

    win_t cfg_q;
    std_e std_in;

    assign std_in = sel_50hz ? STD_50 : STD_60;
    assign cfg    = cfg_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            cfg_q <= calc_window(std_in, out_pix, out_lin,
                                 HF60, HM60, VF60, VM60,
                                 HF50, HM50, VF50, VM50);
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q)); // R9
    AST_CFG_ORDER: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg_q.h_start <= cfg_q.h_stop && cfg_q.v_first <= cfg_q.v_stop)); // R5
    AST_CFG_BOUND: assert property (@(posedge clk) disable iff (rst)
        load |=> (int'(cfg_q.h_stop) <=
                  ((cfg_q.std == STD_50) ? H_LIM50 : H_LIM60))); // R8

endmodule

// File: rtl/vw_decode.sv
module vw_decode
    import vw_pkg::*;
#(
    parameter int HSYNC_CLKS  = 126,
    parameter int VSYNC_LINES = 3,
    parameter int HF60 = 256, parameter int VF60 = 19,
    parameter int HF50 = 284, parameter int VF50 = 23
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] h_cnt,
    input  logic [V_W-1:0] v_cnt,
    input  win_t           cfg,
    output logic           hsync,
    output logic           vsync,
    output logic           active
);

    logic h_in, v_in;

    assign hsync  = (h_cnt < H_W'(HSYNC_CLKS));
    assign vsync  = (v_cnt < V_W'(VSYNC_LINES));
    assign h_in   = (h_cnt >= cfg.h_start) && (h_cnt < cfg.h_stop);
    assign v_in   = (v_cnt >= cfg.v_first) && (v_cnt < cfg.v_stop);
    assign active = h_in && v_in;

    AST_HSYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
        hsync |-> !active); // R3
    AST_VSYNC_BLANK: assert property (@(posedge clk) disable iff (rst)
        vsync |-> !active); // R3
    AST_ACTIVE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(h_cnt) >= ((cfg.std == STD_50) ? HF50 : HF60))); // R4
    AST_ACTIVE_ROWS: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(v_cnt) >= ((cfg.std == STD_50) ? VF50 : VF60))); // R6

endmodule

// File: rtl/video_window_gen.sv
module video_window_gen
    import vw_pkg::*;
#(
    parameter int H_FIRST_60  = 256,
    parameter int H_MAX_60    = 710,
    parameter int H_LEN_60    = 1716,
    parameter int V_FIRST_60  = 19,
    parameter int V_MAX_60    = 240,
    parameter int V_LEN_60    = 262,
    parameter int H_FIRST_50  = 284,
    parameter int H_MAX_50    = 702,
    parameter int H_LEN_50    = 1728,
    parameter int V_FIRST_50  = 23,
    parameter int V_MAX_50    = 287,
    parameter int V_LEN_50    = 312,
    parameter int HSYNC_CLKS  = 126,
    parameter int VSYNC_LINES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_50hz,
    input  logic [PIX_W-1:0] out_pix,
    input  logic [LIN_W-1:0] out_lin,
    output logic [H_W-1:0]   h_cnt,
    output logic [V_W-1:0]   v_cnt,
    output logic             hsync,
    output logic             vsync,
    output logic             active
);

    localparam logic [H_W-1:0] H_LAST_60 = H_W'(H_LEN_60 - 1);
    localparam logic [H_W-1:0] H_LAST_50 = H_W'(H_LEN_50 - 1);
    localparam logic [V_W-1:0] V_LAST_60 = V_W'(V_LEN_60 - 1);
    localparam logic [V_W-1:0] V_LAST_50 = V_W'(V_LEN_50 - 1);

    win_t           cfg;
    logic [H_W-1:0] h_last;
    logic [V_W-1:0] v_last;
    logic           h_wrap, v_wrap, field_end;

    assign h_last    = (cfg.std == STD_50) ? H_LAST_50 : H_LAST_60;
    assign v_last    = (cfg.std == STD_50) ? V_LAST_50 : V_LAST_60;
    assign field_end = h_wrap && v_wrap;

    vw_counter #(.W(H_W)) u_hcnt (
        .clk (clk), .rst (rst), .en (1'b1),
        .last(h_last), .cnt (h_cnt), .wrap(h_wrap)
    );

    vw_counter #(.W(V_W)) u_vcnt (
        .clk (clk), .rst (rst), .en (h_wrap),
        .last(v_last), .cnt (v_cnt), .wrap(v_wrap)
    );

    vw_cfg #(
        .HF60(H_FIRST_60), .HM60(H_MAX_60), .VF60(V_FIRST_60), .VM60(V_MAX_60),
        .HF50(H_FIRST_50), .HM50(H_MAX_50), .VF50(V_FIRST_50), .VM50(V_MAX_50)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (field_end),
        .sel_50hz(sel_50hz),
        .out_pix (out_pix),
        .out_lin (out_lin),
        .cfg     (cfg)
    );

    vw_decode #(
        .HSYNC_CLKS(HSYNC_CLKS), .VSYNC_LINES(VSYNC_LINES),
        .HF60(H_FIRST_60), .VF60(V_FIRST_60),
        .HF50(H_FIRST_50), .VF50(V_FIRST_50)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .h_cnt (h_cnt),
        .v_cnt (v_cnt),
        .cfg   (cfg),
        .hsync (hsync),
        .vsync (vsync),
        .active(active)
    );

    AST_FIELD_RESTART: assert property (@(posedge clk) disable iff (rst)
        field_end |=> (h_cnt == '0 && v_cnt == '0)); // R2
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (h_cnt == '0 && v_cnt == '0 && !active) || rst); // R10

endmodule

// File: tb/video_window_gen_test.sv
module video_window_gen_test;

    localparam int HF60 = 16, HM60 = 40, HL60 = 110;
    localparam int VF60 = 3,  VM60 = 10, VL60 = 16;
    localparam int HF50 = 20, HM50 = 38, HL50 = 104;
    localparam int VF50 = 4,  VM50 = 13, VL50 = 20;
    localparam int HSC  = 8,  VSL  = 2;
    localparam int NCFG = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_50hz = 1'b0;
    logic [9:0]  out_pix = '0;
    logic [8:0]  out_lin = '0;
    logic [10:0] h_cnt;
    logic [8:0]  v_cnt;
    logic        hsync, vsync, active;

    typedef struct {
        int    h;
        int    v;
        bit    hs;
        bit    vs;
        bit    act;
        string tag;
    } exp_t;

    exp_t  q[$];
    exp_t  e;
    int    checks = 0;
    int    fails  = 0;
    bit    mon_on = 1'b0;
    bit    done   = 1'b0;

    int    c_std[NCFG] = '{0, 0, 1, 1, 0, 1};
    int    c_pix[NCFG] = '{40, 20, 38, 100, 0, 11};
    int    c_lin[NCFG] = '{10, 7, 13, 50, 0, 4};
    string c_tag[NCFG] = '{"R4", "R6", "R5", "R8", "R11", "R7"};

    always #2 clk = ~clk;

    video_window_gen #(
        .H_FIRST_60(HF60), .H_MAX_60(HM60), .H_LEN_60(HL60),
        .V_FIRST_60(VF60), .V_MAX_60(VM60), .V_LEN_60(VL60),
        .H_FIRST_50(HF50), .H_MAX_50(HM50), .H_LEN_50(HL50),
        .V_FIRST_50(VF50), .V_MAX_50(VM50), .V_LEN_50(VL50),
        .HSYNC_CLKS(HSC), .VSYNC_LINES(VSL)
    ) uut (
        .clk(clk), .rst(rst), .sel_50hz(sel_50hz),
        .out_pix(out_pix), .out_lin(out_lin),
        .h_cnt(h_cnt), .v_cnt(v_cnt),
        .hsync(hsync), .vsync(vsync), .active(active)
    );

    function automatic int field_len(int s);
        return s ? HL50 * VL50 : HL60 * VL60;
    endfunction

    // Driver side: expected samples of one whole field from the requirements.
    task automatic push_field(int s, int pix, int lin, string tag, bit skip_first);
        int hl = s ? HL50 : HL60;
        int vl = s ? VL50 : VL60;
        int hf = s ? HF50 : HF60;
        int hm = s ? HM50 : HM60;
        int vf = s ? VF50 : VF60;
        int vm = s ? VM50 : VM60;
        int p  = (pix > hm) ? hm : pix;
        int l  = (lin > vm) ? vm : lin;
        int hs = hf + hm - p;
        int he = hs + 2 * p;
        int v0 = vf + (vm - l) / 2;
        int v1 = v0 + l;
        for (int v = 0; v < vl; v++) begin
            for (int h = 0; h < hl; h++) begin
                exp_t x;
                if (skip_first && v == 0 && h == 0) continue;
                x.h   = h;
                x.v   = v;
                x.hs  = (h < HSC);
                x.vs  = (v < VSL);
                x.act = (h >= hs) && (h < he) && (v >= v0) && (v < v1);
                x.tag = tag;
                q.push_back(x);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor side: one sample per clock, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (mon_on && q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (int'(h_cnt) != e.h) begin
                fails++;
                $display("FAIL R1 h_cnt actual=%0d expected=%0d", h_cnt, e.h);
            end
            checks++;
            if (int'(v_cnt) != e.v) begin
                fails++;
                $display("FAIL R2 v_cnt actual=%0d expected=%0d", v_cnt, e.v);
            end
            checks++;
            if (hsync != e.hs || vsync != e.vs) begin
                fails++;
                $display("FAIL R3 sync actual=%0b%0b expected=%0b%0b at h=%0d v=%0d",
                         hsync, vsync, e.hs, e.vs, e.h, e.v);
            end
            checks++;
            if (active != e.act) begin
                fails++;
                $display("FAIL %s/R9 active actual=%0b expected=%0b at h=%0d v=%0d",
                         e.tag, active, e.act, e.h, e.v);
            end
        end
    end

    initial begin
        sel_50hz = c_std[0][0];
        out_pix  = 10'(c_pix[0]);
        out_lin  = 9'(c_lin[0]);
        rst      = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (h_cnt != '0 || v_cnt != '0 || active) begin
            fails++;
            $display("FAIL R10 reset actual h=%0d v=%0d act=%0b expected 0 0 0",
                     h_cnt, v_cnt, active);
        end
        rst = 1'b0;
        push_field(c_std[0], c_pix[0], c_lin[0], c_tag[0], 1'b1);
        mon_on = 1'b1;
        for (int i = 1; i < NCFG; i++) begin
            int half = field_len(c_std[i-1]) / 2;
            while (q.size() > half) @(negedge clk);
            // R9: new request lands mid-field, must wait for the next field
            sel_50hz = c_std[i][0];
            out_pix  = 10'(c_pix[i]);
            out_lin  = 9'(c_lin[i]);
            push_field(c_std[i], c_pix[i], c_lin[i], c_tag[i], 1'b0);
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=not finished expected=finished");
            summary();
            $finish;
        end
    end

endmodule